// File: doc/BRIEF.md
# Expansion Interrupt Collector

This block gathers interrupt requests from up to sixteen board-level sources and presents them to a host processor as one active-high, level-sensitive line. Each source goes through a synchronizer. A rising edge on a synchronized source sets a sticky pending bit. The pending bits are ANDed with an enable mask, and the host line is high while any enabled bit is pending. In a typical board, two of the lines (10 and 11) carry the interrupts of an external dual UART.

Software works through a 16-bit synchronous register bus. The pending register is cleared by writing ones to it. A second register shows the live, synchronized level of every input. The enable mask has no direct write port. It is changed only through two aliases: one sets the bits written as one, and the other clears them. The set alias also reads back the current mask. Software initialises the block by clearing the whole mask and then clearing every pending bit.

Top module: `exp_irq_collector`

## Requirements
- R1: After reset the pending register, the live register and the enable mask all read zero, and `host_irq` is low.
- R2: A pending bit sets on a rising edge of its synchronized input. It becomes readable at the offset 0x16 read issued four cycles after the raw change. It stays set after the input falls.
- R3: A read of offset 0x18 returns the synchronized level of every input, bit n for line n.
- R4: Writing to offset 0x1A sets each mask bit whose data bit is 1 and leaves the other bits unchanged. A read of 0x1A returns the mask.
- R5: Writing to offset 0x1C clears each mask bit whose data bit is 1 and leaves the other bits unchanged. A read of 0x1C returns zero.
- R6: Writing to offset 0x16 clears each pending bit whose data bit is 1. Zero bits leave their pending bits unchanged.
- R7: `host_irq` is high exactly while (pending AND mask) is non-zero.
- R8: If an acknowledge write and a new rising edge hit the same line in the same cycle, the pending bit ends up set.
- R9: A read of any offset other than 0x16, 0x18, 0x1A or 0x1C returns zero. A write to such an offset changes neither the mask nor the pending bits.
- R10: Writing 0xFFFF to 0x1C and then 0xFFFF to 0x16 leaves the mask zero, no bit pending and `host_irq` low.
- R11: A line acknowledged while its input stays high does not become pending again until the input falls and rises again.
- R12: Read data is registered. `reg_rdata` carries the addressed value in the cycle after `reg_rd` is sampled high, and is zero after a cycle with no read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_addr | input | 8 | Register byte offset |
| reg_wr | input | 1 | Write strobe |
| reg_rd | input | 1 | Read strobe |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 16 | Registered read data |
| irq_src | input | 16 | Raw interrupt requests, one per line |
| host_irq | output | 1 | Level interrupt to the host |

## Verification
The bench builds the block with its default parameters: sixteen lines filling the 16-bit data word, an 8-bit offset and a two-stage synchronizer. This choice makes the top line (bit 15) reachable, so the full-width 0xFFFF patterns in the teardown sequence exercise every pending and mask bit. With a two-stage synchronizer, the edge-versus-acknowledge collision can be placed in an exact cycle from the bench.

// File: rtl/irqa_pkg.sv
package irqa_pkg;
   // Register selected by the current bus offset
   typedef enum logic [2:0] {
      SEL_NONE,
      SEL_PENDING,
      SEL_LIVE,
      SEL_EN_SET,
      SEL_EN_CLR
   } regsel_e;

   localparam int DEF_DATA_W = 16;
   localparam int DEF_ADDR_W = 8;
endpackage

// File: rtl/irqa_sync.sv
module irqa_sync #(
   parameter int WIDTH  = 16,
   parameter int STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] d,
   output logic [WIDTH-1:0] q
);
   logic [WIDTH-1:0] stg_q [STAGES];

   genvar gi;
   generate
      for (gi = 0; gi < STAGES; gi++) begin : g_stage
         if (gi == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) stg_q[gi] <= '0;
               else        stg_q[gi] <= d;
            end
         end else begin : g_next
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) stg_q[gi] <= '0;
               else        stg_q[gi] <= stg_q[gi-1];
            end
         end
      end
   endgenerate

   assign q = stg_q[STAGES-1];
endmodule

// File: rtl/irqa_latch.sv
module irqa_latch #(
   parameter int WIDTH = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] level,
   input  logic [WIDTH-1:0] ack,
   output logic [WIDTH-1:0] pending
);
   logic [WIDTH-1:0] prev_q;
   logic [WIDTH-1:0] rise;
   logic [WIDTH-1:0] pend_q;

   assign rise = level & ~prev_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         prev_q <= '0;
         pend_q <= '0;
      end else begin
         prev_q <= level;
         // set dominates acknowledge on the same line
         pend_q <= (pend_q & ~ack) | rise;
      end
   end

   assign pending = pend_q;
endmodule

// File: rtl/irqa_regfile.sv
module irqa_regfile
   import irqa_pkg::*;
#(
   parameter int                  DATA_W    = 16,
   parameter int                  ADDR_W    = 8,
   parameter int                  NUM_LINES = 16,
   parameter logic [ADDR_W-1:0]   OFS_PEND  = 'h16,
   parameter logic [ADDR_W-1:0]   OFS_LIVE  = 'h18,
   parameter logic [ADDR_W-1:0]   OFS_ESET  = 'h1A,
   parameter logic [ADDR_W-1:0]   OFS_ECLR  = 'h1C
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic [ADDR_W-1:0]    addr,
   input  logic                 wr,
   input  logic                 rd,
   input  logic [DATA_W-1:0]    wdata,
   input  logic [NUM_LINES-1:0] pending,
   input  logic [NUM_LINES-1:0] live,
   output logic [NUM_LINES-1:0] mask,
   output logic [NUM_LINES-1:0] ack,
   output logic [DATA_W-1:0]    rdata
);
   localparam int PAD_W = DATA_W - NUM_LINES;

   regsel_e             sel;
   logic [NUM_LINES-1:0] wbits;
   logic [NUM_LINES-1:0] mask_q;
   logic [DATA_W-1:0]    pend_w, live_w, mask_w, rmux;
   logic [DATA_W-1:0]    rdata_q;

   always_comb begin
      if      (addr == OFS_PEND) sel = SEL_PENDING;
      else if (addr == OFS_LIVE) sel = SEL_LIVE;
      else if (addr == OFS_ESET) sel = SEL_EN_SET;
      else if (addr == OFS_ECLR) sel = SEL_EN_CLR;
      else                       sel = SEL_NONE;
   end

   generate
      if (PAD_W == 0) begin : g_full
         assign wbits  = wdata;
         assign pend_w = pending;
         assign live_w = live;
         assign mask_w = mask_q;
      end else begin : g_pad
         assign wbits  = wdata[NUM_LINES-1:0];
         assign pend_w = {{PAD_W{1'b0}}, pending};
         assign live_w = {{PAD_W{1'b0}}, live};
         assign mask_w = {{PAD_W{1'b0}}, mask_q};
      end
   endgenerate

   assign ack = (wr && sel == SEL_PENDING) ? wbits : '0;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                        mask_q <= '0;
      else if (wr && sel == SEL_EN_SET)  mask_q <= mask_q | wbits;
      else if (wr && sel == SEL_EN_CLR)  mask_q <= mask_q & ~wbits;
   end

   always_comb begin
      case (sel)
         SEL_PENDING: rmux = pend_w;
         SEL_LIVE:    rmux = live_w;
         SEL_EN_SET:  rmux = mask_w;
         default:     rmux = '0;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)  rdata_q <= '0;
      else if (rd) rdata_q <= rmux;
      else         rdata_q <= '0;
   end

   assign mask  = mask_q;
   assign rdata = rdata_q;
endmodule

// File: rtl/exp_irq_collector.sv
module exp_irq_collector
   import irqa_pkg::*;
#(
   parameter int NUM_LINES   = 16,
   parameter int DATA_W      = DEF_DATA_W,
   parameter int ADDR_W      = DEF_ADDR_W,
   parameter int SYNC_STAGES = 2
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic [ADDR_W-1:0]    reg_addr,
   input  logic                 reg_wr,
   input  logic                 reg_rd,
   input  logic [DATA_W-1:0]    reg_wdata,
   output logic [DATA_W-1:0]    reg_rdata,
   input  logic [NUM_LINES-1:0] irq_src,
   output logic                 host_irq
);
   generate
      if (NUM_LINES < 1 || NUM_LINES > DATA_W) begin : g_bad_lines
         $error("NUM_LINES must be between 1 and DATA_W");
      end
      if (SYNC_STAGES < 2) begin : g_bad_sync
         $error("SYNC_STAGES must be at least 2");
      end
      if (ADDR_W < 5) begin : g_bad_addr
         $error("ADDR_W too narrow for the register offsets");
      end
   endgenerate

   logic [NUM_LINES-1:0] live_w;
   logic [NUM_LINES-1:0] ack_w;
   logic [NUM_LINES-1:0] pend_w;
   logic [NUM_LINES-1:0] mask_w;

   irqa_sync #(.WIDTH(NUM_LINES), .STAGES(SYNC_STAGES)) u_sync (
      .clk (clk), .rst_n (rst_n), .d (irq_src), .q (live_w)
   );

   irqa_latch #(.WIDTH(NUM_LINES)) u_latch (
      .clk (clk), .rst_n (rst_n), .level (live_w), .ack (ack_w), .pending (pend_w)
   );

   irqa_regfile #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .NUM_LINES(NUM_LINES)) u_regs (
      .clk (clk), .rst_n (rst_n), .addr (reg_addr), .wr (reg_wr), .rd (reg_rd),
      .wdata (reg_wdata), .pending (pend_w), .live (live_w),
      .mask (mask_w), .ack (ack_w), .rdata (reg_rdata)
   );

   assign host_irq = |(pend_w & mask_w);
endmodule

// File: rtl/irqa_chk.sv
module irqa_chk #(
   parameter int NUM_LINES = 16,
   parameter int DATA_W    = 16,
   parameter int ADDR_W    = 8
) (
   input logic                 clk,
   input logic                 rst_n,
   input logic [ADDR_W-1:0]    reg_addr,
   input logic                 reg_wr,
   input logic                 reg_rd,
   input logic [DATA_W-1:0]    reg_wdata,
   input logic [DATA_W-1:0]    reg_rdata,
   input logic                 host_irq,
   input logic [NUM_LINES-1:0] live,
   input logic [NUM_LINES-1:0] pend,
   input logic [NUM_LINES-1:0] mask
);
   logic [NUM_LINES-1:0] wlines;
   logic                 in_map;
   assign wlines = reg_wdata[NUM_LINES-1:0];
   assign in_map = (reg_addr == 'h16) || (reg_addr == 'h18) ||
                   (reg_addr == 'h1A) || (reg_addr == 'h1C);

   AST_MASK_SET: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_wr && reg_addr == 'h1A) |=> ((mask & $past(wlines)) == $past(wlines))); // R4

   AST_MASK_CLR: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_wr && reg_addr == 'h1C) |=> ((mask & $past(wlines)) == '0)); // R5

   AST_ACK_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_wr && reg_addr == 'h16) |=>
         ((pend & $past(wlines) & ~($past(live) & ~$past(live, 2))) == '0)); // R6

   AST_PEND_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      !(reg_wr && reg_addr == 'h16) |=> ((pend & $past(pend)) == $past(pend))); // R2

   AST_IRQ_NEEDS_ENABLED: assert property (@(posedge clk) disable iff (!rst_n)
      host_irq |-> ((pend & mask) != '0)); // R7

   AST_UNMAPPED_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_wr && !in_map) |=> $stable(mask)); // R9

   AST_RDATA_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      !reg_rd |=> (reg_rdata == '0)); // R12
endmodule

bind exp_irq_collector irqa_chk #(
   .NUM_LINES (NUM_LINES), .DATA_W (DATA_W), .ADDR_W (ADDR_W)
) u_chk (
   .clk (clk), .rst_n (rst_n), .reg_addr (reg_addr), .reg_wr (reg_wr),
   .reg_rd (reg_rd), .reg_wdata (reg_wdata), .reg_rdata (reg_rdata),
   .host_irq (host_irq), .live (live_w), .pend (pend_w), .mask (mask_w)
);

// File: tb/tb_exp_irq_collector.sv
module tb_exp_irq_collector;
   localparam logic [7:0] A_PEND = 8'h16;
   localparam logic [7:0] A_LIVE = 8'h18;
   localparam logic [7:0] A_ESET = 8'h1A;
   localparam logic [7:0] A_ECLR = 8'h1C;
   localparam int NVEC = 6;
   // {raw input pattern, mask to enable}
   localparam logic [31:0] VEC [NVEC] = '{
      {16'h0001, 16'h0001}, {16'h0C00, 16'h0400}, {16'h8000, 16'h0000},
      {16'hFFFF, 16'hFFFF}, {16'hA5A5, 16'h5A5A}, {16'h0C00, 16'h0C00}
   };

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [7:0]  reg_addr = '0;
   logic        reg_wr = 1'b0;
   logic        reg_rd = 1'b0;
   logic [15:0] reg_wdata = '0;
   logic [15:0] reg_rdata;
   logic [15:0] irq_src = '0;
   logic        host_irq;

   int n_chk = 0;
   int n_bad = 0;
   logic [15:0] rv;

   always #5 clk = ~clk;

   exp_irq_collector dut (
      .clk (clk), .rst_n (rst_n), .reg_addr (reg_addr), .reg_wr (reg_wr),
      .reg_rd (reg_rd), .reg_wdata (reg_wdata), .reg_rdata (reg_rdata),
      .irq_src (irq_src), .host_irq (host_irq)
   );

   task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic wr_reg(input logic [7:0] a, input logic [15:0] d);
      reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
      @(posedge clk); @(negedge clk);
      reg_wr = 1'b0; reg_wdata = '0;
   endtask

   task automatic rd_reg(input logic [7:0] a, output logic [15:0] d);
      reg_addr = a; reg_rd = 1'b1;
      @(posedge clk); @(negedge clk);
      d = reg_rdata; reg_rd = 1'b0;
   endtask

   task automatic wait_cyc(input int n);
      for (int i = 0; i < n; i++) @(negedge clk);
   endtask

   task automatic finish_run();
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   endtask

   initial begin
      #2_000_000;
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual hung expected done");
      finish_run();
   end

   initial begin
      wait_cyc(3);
      rst_n = 1'b1;
      wait_cyc(1);

      // R1 reset state
      rd_reg(A_PEND, rv); check("R1 pending", rv, 16'h0000);
      rd_reg(A_LIVE, rv); check("R1 live", rv, 16'h0000);
      rd_reg(A_ESET, rv); check("R1 mask", rv, 16'h0000);
      check("R1 host_irq", {15'b0, host_irq}, 16'h0000);

      // table walk: R2 R3 R4 R7
      for (int v = 0; v < NVEC; v++) begin
         logic [15:0] raw, msk;
         raw = VEC[v][31:16];
         msk = VEC[v][15:0];
         wr_reg(A_ECLR, 16'hFFFF);
         irq_src = '0;
         wait_cyc(4);
         wr_reg(A_PEND, 16'hFFFF);
         wr_reg(A_ESET, msk);
         irq_src = raw;
         wait_cyc(4);
         rd_reg(A_PEND, rv); check("R2 pending after edge", rv, raw);
         rd_reg(A_LIVE, rv); check("R3 live level", rv, raw);
         rd_reg(A_ESET, rv); check("R4 mask readback", rv, msk);
         check("R7 host_irq", {15'b0, host_irq}, {15'b0, |(raw & msk)});
      end

      // R2 pending stays after input falls
      irq_src = '0;
      wait_cyc(4);
      rd_reg(A_PEND, rv); check("R2 sticky after fall", rv, 16'h0C00);
      rd_reg(A_LIVE, rv); check("R3 live after fall", rv, 16'h0000);

      // R12 idle read data
      wait_cyc(1);
      check("R12 rdata idle", reg_rdata, 16'h0000);

      // R9 unmapped offsets
      wr_reg(A_ECLR, 16'hFFFF);
      wr_reg(A_ESET, 16'h0F0F);
      wr_reg(8'h1E, 16'hFFFF);
      wr_reg(8'h00, 16'hFFFF);
      rd_reg(A_ESET, rv); check("R9 mask unchanged", rv, 16'h0F0F);
      rd_reg(A_PEND, rv); check("R9 pending unchanged", rv, 16'h0C00);
      rd_reg(8'h1E, rv);  check("R9 unmapped read", rv, 16'h0000);
      rd_reg(8'h17, rv);  check("R9 odd offset read", rv, 16'h0000);
      rd_reg(A_ECLR, rv); check("R5 clear alias reads zero", rv, 16'h0000);

      // R5 partial mask clear
      wr_reg(A_ESET, 16'hFFFF);
      wr_reg(A_ECLR, 16'h00F0);
      rd_reg(A_ESET, rv); check("R5 partial clear", rv, 16'hFF0F);

      // R6 partial acknowledge; R7 masked vs enabled
      wr_reg(A_PEND, 16'hFFFF);
      irq_src = 16'hA5A5; wait_cyc(4);
      irq_src = 16'h0000; wait_cyc(4);
      wr_reg(A_PEND, 16'h0005);
      rd_reg(A_PEND, rv); check("R6 partial ack", rv, 16'hA5A0);
      wr_reg(A_ECLR, 16'hFFFF);
      wr_reg(A_ESET, 16'h5A5A);
      check("R7 low when none enabled", {15'b0, host_irq}, 16'h0000);
      wr_reg(A_ESET, 16'h0020);
      check("R7 high when enabled", {15'b0, host_irq}, 16'h0001);

      // R11 ack while held high, no re-latch
      wr_reg(A_PEND, 16'hFFFF);
      irq_src = 16'h0040; wait_cyc(4);
      wr_reg(A_PEND, 16'h0040);
      wait_cyc(4);
      rd_reg(A_PEND, rv); check("R11 no relatch while high", rv, 16'h0000);
      irq_src = 16'h0000; wait_cyc(4);
      irq_src = 16'h0040; wait_cyc(4);
      rd_reg(A_PEND, rv); check("R11 relatch on new edge", rv, 16'h0040);
      irq_src = 16'h0000; wait_cyc(4);
      wr_reg(A_PEND, 16'hFFFF);

      // R8 set wins: line 3 already pending, new edge coincides with ack
      irq_src = 16'h0008; wait_cyc(4);
      irq_src = 16'h0000; wait_cyc(4);
      irq_src = 16'h0008;
      @(posedge clk);
      @(posedge clk);
      @(negedge clk);
      wr_reg(A_PEND, 16'h0008);
      rd_reg(A_PEND, rv); check("R8 set beats ack", rv, 16'h0008);
      wr_reg(A_PEND, 16'h0008);
      rd_reg(A_PEND, rv); check("R8 plain ack clears", rv, 16'h0000);
      irq_src = 16'h0000; wait_cyc(4);

      // R10 full teardown
      irq_src = 16'hFFFF; wait_cyc(4);
      irq_src = 16'h0000; wait_cyc(4);
      wr_reg(A_ESET, 16'hFFFF);
      check("R10 irq before teardown", {15'b0, host_irq}, 16'h0001);
      wr_reg(A_ECLR, 16'hFFFF);
      wr_reg(A_PEND, 16'hFFFF);
      rd_reg(A_ESET, rv); check("R10 mask cleared", rv, 16'h0000);
      rd_reg(A_PEND, rv); check("R10 pending cleared", rv, 16'h0000);
      check("R10 host_irq low", {15'b0, host_irq}, 16'h0000);

      finish_run();
   end
endmodule